// File: doc/BRIEF.md
# I2C Target Responder with Clock Stretching

This block is the target (slave) half of an I2C controller. It watches the two open-drain bus lines, finds start and stop conditions, and compares each address byte against a 7-bit own address held in a register. When the address matches, or a general call arrives and is allowed, the block acknowledges. It raises an address-detected flag and reports whether the master reads or writes.

Every byte is paced by software. After the address acknowledge, after each received byte (before its acknowledge bit) and after each transmitted byte the master acknowledged, the block pulls SCL low. It holds SCL there until software pulses `tb_set`. For a master read, the pulse also latches the next byte from `tx_data`. For a master write, the byte is already on `rx_data`, and the level of `nak_sel` at the pulse decides whether the block answers ACK or NAK. A stop that closes an addressed transfer raises a stop flag. While `master_sel` is high the target function is switched off. Control and status pins are plain levels. A transfer step is a single-cycle `tb_set` pulse, and the block applies no back-pressure except by holding SCL.

Top module: `i2c_tgt_stretch`

## Requirements
- R1: After reset the own address reads 0x01, the flags `sad`, `ssd`, `gcad` and `irq` are 0, `bus_busy` is 0, and neither line is pulled low.
- R2: The address byte arrives MSB first: seven address bits, then the direction bit (1 = master reads). When the address equals the own address, the block pulls SDA low for the 9th bit, sets `sad`, and sets `rwm` to the direction bit.
- R3: An address byte that does not match leaves SDA released during the 9th bit and sets no flag.
- R4: Address 0 with the direction bit 0 is a general call. It is acknowledged and sets both `sad` and `gcad` while `gc_disable` is 0. When `gc_disable` is 1 it is treated as a mismatch.
- R5: After the address acknowledge, and before the acknowledge bit of each received byte, SCL stays pulled low until a `tb_set` pulse. A `tb_set` pulse while the block is not holding SCL changes neither line.
- R6: In a master read, the byte on `tx_data` at the `tb_set` pulse is shifted out MSB first. A master ACK (SDA low on the 9th bit) makes the block hold SCL again. A master NAK sets `ack_nak` to 1 and releases both lines until the next start or stop.
- R7: In a master write, the eight bits are captured MSB first and shown on `rx_data` while SCL is held. The acknowledge bit is low if `nak_sel` was 0 at the `tb_set` pulse and high if it was 1.
- R8: A stop condition ending a transfer in which the block was addressed sets `ssd`. A stop after an unaddressed transfer does not.
- R9: `bus_busy` is 1 from any start condition until the next stop condition, whoever the bus master is.
- R10: While `master_sel` is 1 the block answers no address and releases both lines within one cycle, even if it was holding SCL and `tb_set` arrives in the same cycle.
- R11: `irq` is the OR of (`sad` and `irq_en[0]`) and (`ssd` and `irq_en[1]`). Writing a 1 to `flag_clr` bit 0, 1 or 2 clears `sad`, `ssd` or `gcad`. A flag being set in the same cycle wins over its clear.
- R12: A cycle with `addr_we` high loads `addr_wd` into the own address, and `own_addr` reads it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| scl_oe | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| master_sel | input | 1 | 1 disables the target function |
| gc_disable | input | 1 | 1 ignores general call |
| nak_sel | input | 1 | Answer to a received byte, sampled at `tb_set`: 0 ACK, 1 NAK |
| tb_set | input | 1 | Single-cycle pulse that releases a held SCL |
| tx_data | input | 8 | Byte to transmit, sampled at `tb_set` |
| rx_data | output | 8 | Last byte received |
| addr_we | input | 1 | Own-address write strobe |
| addr_wd | input | 7 | Own-address write data |
| own_addr | output | 7 | Current own address |
| flag_clr | input | 3 | Write-1-clear: bit0 `sad`, bit1 `ssd`, bit2 `gcad` |
| irq_en | input | 2 | Interrupt enables: bit0 `sad`, bit1 `ssd` |
| sad | output | 1 | Address detected flag |
| ssd | output | 1 | Stop after addressed transfer flag |
| gcad | output | 1 | General call detected flag |
| rwm | output | 1 | Direction of the current transfer, 1 = block transmits |
| ack_nak | output | 1 | Master's answer after the last transmitted byte, 1 = NAK |
| bus_busy | output | 1 | Bus occupied between start and stop |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a stop condition that ends an addressed transfer: it must set `ssd` and drop `bus_busy` on the same detected edge, and the bench checks both right after each stop. The second pair is a master-mode takeover against a pending byte release. The bench waits until the block holds SCL at the start of a master read, then raises `master_sel` and pulses `tb_set` with `tx_data` = 0x00 in the same cycle. The takeover must win: SDA stays released, although the byte's first bit would have pulled it low, and SCL is freed. Randomized transfers mix matching, foreign and general-call addresses, both directions and random ACK/NAK answers, each judged against a bench model of the address rules.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int FLG_SAD = 0;
  localparam int FLG_SSD = 1;
  localparam int FLG_GCA = 2;
  localparam int IE_SAD  = 0;
  localparam int IE_SSD  = 1;

  typedef enum logic [3:0] {
    ST_IDLE,   // not addressed
    ST_ADDR,   // shifting in the address byte
    ST_AACK,   // driving the address acknowledge
    ST_HOLD,   // SCL stretched, waiting for a release pulse
    ST_TX,     // shifting a byte out
    ST_TACK,   // sampling the master's answer
    ST_RX,     // shifting a byte in
    ST_RHOLD,  // byte received, SCL stretched before its acknowledge
    ST_RACK,   // driving the receive acknowledge
    ST_WAIT    // released, waiting for start or stop
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_inflt.sv
module i2c_tgt_inflt #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= '1;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      if (&hist_q)       dout <= 1'b1;
      else if (~|hist_q) dout <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic bus_busy
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bus_busy <= 1'b0;
    else if (start_det) bus_busy <= 1'b1;
    else if (stop_det)  bus_busy <= 1'b0;
  end
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_f,
  input  logic              master_sel,
  input  logic              gc_disable,
  input  logic              nak_sel,
  input  logic              tb_set,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [DATA_W-2:0] own_addr,
  input  logic [2:0]        flag_clr,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rwm,
  output logic              ack_nak,
  output logic              sad,
  output logic              ssd,
  output logic              gcad
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  tgt_state_e        st;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] sh;
  logic              in_xfer;
  logic              own_hit, gc_hit;

  assign gc_hit  = (sh[DATA_W-1:1] == '0) && !sh[0] && !gc_disable;
  assign own_hit = (sh[DATA_W-1:1] == own_addr) || gc_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      sh      <= '0;
      in_xfer <= 1'b0;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
      rx_data <= '0;
      rwm     <= 1'b0;
      ack_nak <= 1'b0;
      sad     <= 1'b0;
      ssd     <= 1'b0;
      gcad    <= 1'b0;
    end else begin
      if (flag_clr[FLG_SAD]) sad  <= 1'b0;
      if (flag_clr[FLG_SSD]) ssd  <= 1'b0;
      if (flag_clr[FLG_GCA]) gcad <= 1'b0;

      if (master_sel) begin
        st      <= ST_IDLE;
        scl_oe  <= 1'b0;
        sda_oe  <= 1'b0;
        in_xfer <= 1'b0;
      end else if (stop_det) begin
        st     <= ST_IDLE;
        scl_oe <= 1'b0;
        sda_oe <= 1'b0;
        if (in_xfer) ssd <= 1'b1;
        in_xfer <= 1'b0;
      end else if (start_det) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        scl_oe <= 1'b0;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR: begin
            if (scl_rise) begin
              sh  <= {sh[DATA_W-2:0], sda_f};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == CNT_FULL) begin
              if (own_hit) begin
                st      <= ST_AACK;
                sda_oe  <= 1'b1;
                sad     <= 1'b1;
                gcad    <= gc_hit;
                rwm     <= sh[0];
                in_xfer <= 1'b1;
              end else begin
                st <= ST_WAIT;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              scl_oe <= 1'b1;
              st     <= ST_HOLD;
            end
          end
          ST_HOLD: begin
            if (tb_set) begin
              scl_oe <= 1'b0;
              cnt    <= '0;
              if (rwm) begin
                sh     <= tx_data;
                sda_oe <= ~tx_data[DATA_W-1];
                st     <= ST_TX;
              end else begin
                st <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              cnt <= cnt + 1'b1;
              if (cnt == CNT_LAST) begin
                sda_oe <= 1'b0;
                st     <= ST_TACK;
              end else begin
                sh     <= {sh[DATA_W-2:0], 1'b0};
                sda_oe <= ~sh[DATA_W-2];
              end
            end
          end
          ST_TACK: begin
            if (scl_rise) ack_nak <= sda_f;
            else if (scl_fall) begin
              if (!ack_nak) begin
                scl_oe <= 1'b1;
                st     <= ST_HOLD;
              end else begin
                st <= ST_WAIT;
              end
            end
          end
          ST_RX: begin
            if (scl_rise) begin
              sh  <= {sh[DATA_W-2:0], sda_f};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == CNT_FULL) begin
              rx_data <= sh;
              scl_oe  <= 1'b1;
              st      <= ST_RHOLD;
            end
          end
          ST_RHOLD: begin
            if (tb_set) begin
              sda_oe <= ~nak_sel;
              scl_oe <= 1'b0;
              st     <= ST_RACK;
            end
          end
          ST_RACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              st     <= ST_RX;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_tgt_stretch.sv
module i2c_tgt_stretch
  import i2c_tgt_pkg::*;
#(
  parameter int              DATA_W      = 8,
  parameter int              SYNC_STAGES = 2,
  parameter int              FILT_LEN    = 2,
  parameter logic [DATA_W-2:0] RST_ADDR  = 7'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              master_sel,
  input  logic              gc_disable,
  input  logic              nak_sel,
  input  logic              tb_set,
  input  logic [DATA_W-1:0] tx_data,
  output logic [DATA_W-1:0] rx_data,
  input  logic              addr_we,
  input  logic [DATA_W-2:0] addr_wd,
  output logic [DATA_W-2:0] own_addr,
  input  logic [2:0]        flag_clr,
  input  logic [1:0]        irq_en,
  output logic              sad,
  output logic              ssd,
  output logic              gcad,
  output logic              rwm,
  output logic              ack_nak,
  output logic              bus_busy,
  output logic              irq
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_lines, flt_lines;
  logic scl_rise, scl_fall, start_det, stop_det;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    i2c_tgt_inflt #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_flt (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_lines[g]),
      .dout (flt_lines[g])
    );
  end

  i2c_tgt_cond u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (flt_lines[0]),
    .sda_f    (flt_lines[1]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .bus_busy (bus_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       own_addr <= RST_ADDR;
    else if (addr_we) own_addr <= addr_wd;
  end

  i2c_tgt_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_f     (flt_lines[1]),
    .master_sel(master_sel),
    .gc_disable(gc_disable),
    .nak_sel   (nak_sel),
    .tb_set    (tb_set),
    .tx_data   (tx_data),
    .own_addr  (own_addr),
    .flag_clr  (flag_clr),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .rx_data   (rx_data),
    .rwm       (rwm),
    .ack_nak   (ack_nak),
    .sad       (sad),
    .ssd       (ssd),
    .gcad      (gcad)
  );

  assign irq = (sad & irq_en[IE_SAD]) | (ssd & irq_en[IE_SSD]);
endmodule

// File: rtl/i2c_tgt_stretch_chk.sv
module i2c_tgt_stretch_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_oe,
  input logic sda_oe,
  input logic tb_set,
  input logic master_sel,
  input logic gc_disable,
  input logic start_det,
  input logic stop_det,
  input logic bus_busy,
  input logic sad,
  input logic ssd,
  input logic gcad
);
  AST_ADDR_ACK_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sad) |-> sda_oe); // R2

  AST_GC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gcad) |-> $past(!gc_disable)); // R4

  AST_HOLD_UNTIL_TB: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe && !tb_set && !master_sel && !stop_det && !start_det) |=> scl_oe); // R5

  AST_SSD_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ssd) |-> $past(stop_det)); // R8

  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> bus_busy); // R9

  AST_IDLE_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !bus_busy); // R9

  AST_QUIET_IN_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    master_sel |=> (!scl_oe && !sda_oe)); // R10
endmodule

bind i2c_tgt_stretch i2c_tgt_stretch_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_oe    (scl_oe),
  .sda_oe    (sda_oe),
  .tb_set    (tb_set),
  .master_sel(master_sel),
  .gc_disable(gc_disable),
  .start_det (start_det),
  .stop_det  (stop_det),
  .bus_busy  (bus_busy),
  .sad       (sad),
  .ssd       (ssd),
  .gcad      (gcad)
);

// File: tb/i2c_tgt_stretch_bench.sv
`timescale 1ns/1ps
module i2c_tgt_stretch_bench;
  localparam int H = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_oe, sda_oe;
  logic scl_bus, sda_bus;
  assign scl_bus = scl_m & ~scl_oe;
  assign sda_bus = sda_m & ~sda_oe;

  logic master_sel = 1'b0, gc_disable = 1'b0, nak_sel = 1'b0, tb_set = 1'b0, addr_we = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic [6:0] addr_wd = 7'h00;
  logic [2:0] flag_clr = 3'b000;
  logic [1:0] irq_en = 2'b00;
  logic [7:0] rx_data;
  logic [6:0] own_addr;
  logic sad, ssd, gcad, rwm, ack_nak, bus_busy, irq;

  int checks = 0;
  int fails = 0;
  logic [6:0] own_sh = 7'h01;
  bit done = 1'b0;

  i2c_tgt_stretch u_i2c_tgt_stretch (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .master_sel(master_sel),
    .gc_disable(gc_disable), .nak_sel(nak_sel), .tb_set(tb_set),
    .tx_data(tx_data), .rx_data(rx_data), .addr_we(addr_we),
    .addr_wd(addr_wd), .own_addr(own_addr), .flag_clr(flag_clr),
    .irq_en(irq_en), .sad(sad), .ssd(ssd), .gcad(gcad), .rwm(rwm),
    .ack_nak(ack_nak), .bus_busy(bus_busy), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_hit(input logic [6:0] a, input bit rw, input logic [6:0] own,
                                 input bit gcd, input bit msel);
    return !msel && ((a == own) || (a == 7'h00 && !rw && !gcd));
  endfunction

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_high;
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic m_start;
    sda_m = 1'b1; wt(H);
    scl_m = 1'b1; wait_high(); wt(H);
    sda_m = 1'b0; wt(H);
    scl_m = 1'b0; wt(H);
  endtask

  task automatic m_stop;
    sda_m = 1'b0; wt(H);
    scl_m = 1'b1; wait_high(); wt(H);
    sda_m = 1'b1; wt(H);
  endtask

  task automatic m_wbit(input logic b);
    sda_m = b; wt(H);
    scl_m = 1'b1; wait_high(); wt(H);
    scl_m = 1'b0; wt(H);
  endtask

  task automatic m_rbit(output logic b);
    sda_m = 1'b1; wt(H);
    scl_m = 1'b1; wait_high(); wt(H);
    b = sda_bus;
    scl_m = 1'b0; wt(H);
  endtask

  task automatic m_wbyte(input logic [7:0] d);
    for (int i = 7; i >= 0; i--) m_wbit(d[i]);
  endtask

  task automatic m_rbyte(output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      m_rbit(b);
      d[i] = b;
    end
  endtask

  task automatic pulse_tb(input logic [7:0] d, input logic nk);
    @(negedge clk);
    tx_data = d; nak_sel = nk; tb_set = 1'b1;
    @(negedge clk);
    tb_set = 1'b0;
  endtask

  task automatic clear_flags;
    @(negedge clk); flag_clr = 3'b111;
    @(negedge clk); flag_clr = 3'b000;
  endtask

  task automatic do_xfer(input logic [6:0] a, input bit rw, input int nb, input bit gcd);
    logic hit, gc, b, nk;
    logic [7:0] d, got;
    gc_disable = gcd;
    clear_flags();
    hit = exp_hit(a, rw, own_sh, gcd, master_sel);
    gc  = hit && (a == 7'h00);
    m_start();
    chk("R9 busy after start", bus_busy, 1);
    m_wbyte({a, rw});
    m_rbit(b);
    if (hit) chk("R2 address acknowledged", b, 0);
    else     chk("R3 address not acknowledged", b, 1);
    chk(hit ? "R2 sad set" : "R3 sad stays clear", sad, hit);
    chk("R4 gcad", gcad, gc);
    if (hit) begin
      chk("R2 direction", rwm, rw);
      chk("R5 stretch after address", scl_oe, 1);
      wt(30);
      chk("R5 stretch still held", scl_oe, 1);
      for (int i = 0; i < nb; i++) begin
        if (rw) begin
          d = 8'($urandom);
          pulse_tb(d, 1'b0);
          m_rbyte(got);
          chk("R6 transmitted byte", got, d);
          m_wbit(i == nb - 1);
          if (i == nb - 1) begin
            chk("R6 NAK seen", ack_nak, 1);
            chk("R6 lines released after NAK", {scl_oe, sda_oe}, 0);
          end else begin
            chk("R6 stretch after master ACK", scl_oe, 1);
          end
        end else begin
          if (i == 0) pulse_tb(8'h00, 1'b0);
          d = 8'($urandom);
          m_wbyte(d);
          chk("R7 received byte", rx_data, d);
          chk("R5 stretch before data ack", scl_oe, 1);
          nk = 1'($urandom);
          pulse_tb(8'h00, nk);
          m_rbit(b);
          chk("R7 ack bit follows nak_sel", b, nk);
        end
      end
    end else begin
      pulse_tb(8'h00, 1'b0);
      chk("R5 stray tb_set ignored", {scl_oe, sda_oe}, 0);
    end
    m_stop();
    chk("R9 idle after stop", bus_busy, 0);
    chk("R8 ssd after stop", ssd, hit);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic b;
    logic [7:0] got;
    void'($urandom(32'd20240611));
    wt(5);
    rst_n = 1'b1;
    wt(5);
    // R1 reset state
    chk("R1 own address", own_addr, 7'h01);
    chk("R1 flags", {sad, ssd, gcad, irq}, 0);
    chk("R1 bus idle", bus_busy, 0);
    chk("R1 lines released", {scl_oe, sda_oe}, 0);

    do_xfer(7'h01, 1'b0, 2, 1'b0);

    // R11 interrupt combination and clearing
    irq_en = 2'b00; wt(2);
    chk("R11 irq masked", irq, 0);
    irq_en = 2'b01; wt(2);
    chk("R11 irq from sad", irq, 1);
    flag_clr = 3'b001; wt(1); flag_clr = 3'b000; wt(1);
    chk("R11 sad cleared", {sad, ssd}, 2'b01);
    chk("R11 irq drops with sad", irq, 0);
    irq_en = 2'b10; wt(2);
    chk("R11 irq from ssd", irq, 1);
    flag_clr = 3'b010; wt(1); flag_clr = 3'b000; wt(1);
    chk("R11 irq after ssd clear", irq, 0);
    irq_en = 2'b00;

    // R12 own address update
    @(negedge clk); addr_wd = 7'h5A; addr_we = 1'b1;
    @(negedge clk); addr_we = 1'b0;
    chk("R12 own address readback", own_addr, 7'h5A);
    own_sh = 7'h5A;
    do_xfer(7'h01, 1'b0, 1, 1'b0);
    do_xfer(7'h5A, 1'b1, 2, 1'b0);

    // R4 general call gating
    do_xfer(7'h00, 1'b0, 1, 1'b1);
    do_xfer(7'h00, 1'b0, 2, 1'b0);
    do_xfer(7'h00, 1'b1, 1, 1'b0);

    // R10 master mode ignores the address
    master_sel = 1'b1;
    do_xfer(own_sh, 1'b0, 1, 1'b0);
    master_sel = 1'b0;

    // R10 takeover and release pulse in the same cycle
    clear_flags();
    m_start();
    m_wbyte({own_sh, 1'b1});
    m_rbit(b);
    chk("R2 ack before takeover", b, 0);
    chk("R5 held before takeover", scl_oe, 1);
    @(negedge clk);
    master_sel = 1'b1; tb_set = 1'b1; tx_data = 8'h00;
    @(negedge clk);
    tb_set = 1'b0;
    wt(2);
    chk("R10 lines released on takeover", {scl_oe, sda_oe}, 0);
    wt(H);
    chk("R10 SDA stays released", sda_oe, 0);
    m_stop();
    master_sel = 1'b0;

    // R6 NAK then repeated start
    clear_flags();
    m_start();
    m_wbyte({own_sh, 1'b1});
    m_rbit(b);
    pulse_tb(8'h81, 1'b0);
    m_rbyte(got);
    chk("R6 byte before NAK", got, 8'h81);
    m_wbit(1'b1);
    chk("R6 released after NAK", {scl_oe, sda_oe}, 0);
    clear_flags();
    m_start();
    chk("R9 busy through repeated start", bus_busy, 1);
    m_wbyte({own_sh, 1'b0});
    m_rbit(b);
    chk("R2 ack after repeated start", b, 0);
    chk("R2 write direction after restart", {sad, rwm}, 2'b10);
    pulse_tb(8'h00, 1'b0);
    m_stop();
    chk("R8 ssd after restart transfer", ssd, 1);

    // randomized transfers
    for (int t = 0; t < 14; t++) begin
      logic [6:0] a;
      int sel;
      sel = int'($urandom % 4);
      if (sel == 0)      a = own_sh;
      else if (sel == 1) a = 7'h00;
      else               a = 7'($urandom);
      do_xfer(a, 1'($urandom), 1 + int'($urandom % 3), 1'($urandom));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule